// File: doc/BRIEF.md
# Program Memory Fetch Strobe Controller

This block drives the active-low read strobe for an external program store in a small 8-bit microcontroller core. It works from the core's machine-cycle timing. Each machine cycle lasts twelve oscillator clocks and is split into six states. Each state has two phases. At the start of every machine cycle the block looks at the pending code fetch. It decides whether the fetch is served by the on-chip code store or by the external one, and it raises a select output for external fetches.

The external-access pin chooses the memory. When it is low, every fetch goes off chip. When it is high, the on-chip store serves addresses up to 3FFFh, and anything higher goes off chip. The block captures the pin while reset is held. It keeps that value for as long as the chip runs, so a change on the pin during operation cannot move the code source in the middle of a program.

For an external fetch the strobe gives two pulses per machine cycle. Each pulse is four clocks long, one in each half of the cycle. If the core reports that the same machine cycle carries an external data-memory transfer, the block drops both pulses. The bus then belongs to that transfer.

Top module: `pmem_strobe_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls until the first machine-cycle start, `pmem_rd_n` is 1 and `fetch_ext` is 0.
- R2: With the latched external-access value at 1, a fetch whose address is 3FFFh or lower is internal: `fetch_ext` is 0.
- R3: With the latched external-access value at 1, a fetch whose address is 4000h or higher is external: `fetch_ext` is 1.
- R4: With the latched external-access value at 0, every requested fetch is external, whatever its address.
- R5: `mc_state` encodes S1..S6 as 0..5, and `mc_phase` is 0 for the first half of a state. For an external fetch, `pmem_rd_n` is 0 exactly in the clock after each clock with `mc_state` equal to 0, 1, 3 or 4. In every other clock it is 1. Over one machine cycle, bit k of the 12-bit pattern sampled one clock after oscillator clock k is therefore C30h.
- R6: When `xdata_cycle` is 1 at the cycle start, `pmem_rd_n` stays 1 for the whole machine cycle, even if the fetch is external. `fetch_ext` still shows the decision.
- R7: An internal fetch never drives `pmem_rd_n` low.
- R8: `ea_pin` is captured on every clock while `rst` is 1 and held from then on. Changes on it after reset have no effect.
- R9: `fetch_req`, `fetch_addr` and `xdata_cycle` are taken only at the cycle start (`mc_state`=0, `mc_phase`=0). Changes later in the same machine cycle have no effect on the strobe or `fetch_ext`.
- R10: A machine cycle that starts with `fetch_req` at 0 gives no strobe and `fetch_ext` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ea_pin | input | 1 | External-access select, latched during reset |
| mc_state | input | 3 | Machine-cycle state, 0..5 for S1..S6 |
| mc_phase | input | 1 | Phase within the state, 0 = first |
| fetch_req | input | 1 | A code fetch is pending for this machine cycle |
| fetch_addr | input | ADDR_W | Program counter of the pending fetch |
| xdata_cycle | input | 1 | This machine cycle performs an external data access |
| pmem_rd_n | output | 1 | External program memory read strobe, active low |
| fetch_ext | output | 1 | Current fetch is served externally |

## Verification
The main collision is an external code fetch and an external data transfer starting in the same machine cycle. The bench provokes it by raising `xdata_cycle` at the cycle start while the fetch address is above the internal limit or the external-access value is low. The whole 12-clock strobe pattern must then read FFFh while `fetch_ext` still reads 1. A back-to-back run checks that the cycle after such a collision strobes normally again. A related case raises `xdata_cycle` only in the middle of an external-fetch cycle, and the full C30h pattern must survive it.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam logic [DEF_ADDR_W-1:0] DEF_INT_TOP = 16'h3FFF;

    typedef enum logic [2:0] {
        ST_S1 = 3'd0,
        ST_S2 = 3'd1,
        ST_S3 = 3'd2,
        ST_S4 = 3'd3,
        ST_S5 = 3'd4,
        ST_S6 = 3'd5
    } mstate_e;

    // Per machine cycle fetch context, frozen at the cycle start
    typedef struct packed {
        logic fetch;   // a fetch was requested
        logic ext;     // that fetch goes to external memory
        logic data;    // cycle also carries an external data transfer
    } cyc_flags_t;

    // States in which the strobe may be low: first pulse S1..S2, second S4..S5
    function automatic logic in_pulse(input logic [2:0] st);
        return (st == ST_S1) || (st == ST_S2) || (st == ST_S4) || (st == ST_S5);
    endfunction

endpackage

// File: rtl/pfs_access_sel.sv
module pfs_access_sel
    import pfs_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] INT_TOP = DEF_INT_TOP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ea_pin,
    input  logic [ADDR_W-1:0] addr,
    output logic              ext_dec
);

    logic ea_q;

    // The pin is tracked only while reset is held
    always_ff @(posedge clk) begin
        if (rst) ea_q <= ea_pin;
    end

    always_comb begin
        ext_dec = !ea_q || (addr > INT_TOP);
    end

    p_ea_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(ea_q));

    p_ea_low_ext_r4: assert property (@(posedge clk) disable iff (rst)
        !ea_q |-> ext_dec);

endmodule

// File: rtl/pfs_cycle_track.sv
module pfs_cycle_track
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       req,
    input  logic       ext_dec,
    input  logic       data,
    output cyc_flags_t now_f,
    output cyc_flags_t held_f
);

    cyc_flags_t held_q;

    always_comb begin
        if (start) begin
            now_f.fetch = req;
            now_f.ext   = req & ext_dec;
            now_f.data  = data;
        end else begin
            now_f = held_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        held_q <= '0;
        else if (start) held_q <= now_f;
    end

    assign held_f = held_q;

    p_hold_mid_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(start) && !$past(rst)) |-> $stable(held_q));

    p_no_req_no_ext_r10: assert property (@(posedge clk) disable iff (rst)
        !held_q.fetch |-> !held_q.ext);

endmodule

// File: rtl/pfs_strobe_gen.sv
module pfs_strobe_gen
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] state,
    input  cyc_flags_t flags,
    output logic       strobe_n
);

    logic fire;

    always_comb begin
        fire = in_pulse(state) && flags.fetch && flags.ext && !flags.data;
    end

    always_ff @(posedge clk) begin
        if (rst) strobe_n <= 1'b1;
        else     strobe_n <= !fire;
    end

    p_slot_only_r5: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> $past(in_pulse(state)));

endmodule

// File: rtl/pmem_strobe_ctrl.sv
module pmem_strobe_ctrl
    import pfs_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] INT_TOP = DEF_INT_TOP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ea_pin,
    input  logic [2:0]        mc_state,
    input  logic              mc_phase,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              xdata_cycle,
    output logic              pmem_rd_n,
    output logic              fetch_ext
);

    logic       start;
    logic       ext_dec;
    cyc_flags_t now_f;
    cyc_flags_t held_f;

    always_comb begin
        start = (mc_state == ST_S1) && !mc_phase;
    end

    pfs_access_sel #(
        .ADDR_W  (ADDR_W),
        .INT_TOP (INT_TOP)
    ) u_sel (
        .clk     (clk),
        .rst     (rst),
        .ea_pin  (ea_pin),
        .addr    (fetch_addr),
        .ext_dec (ext_dec)
    );

    pfs_cycle_track u_track (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .req     (fetch_req),
        .ext_dec (ext_dec),
        .data    (xdata_cycle),
        .now_f   (now_f),
        .held_f  (held_f)
    );

    pfs_strobe_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .state    (mc_state),
        .flags    (now_f),
        .strobe_n (pmem_rd_n)
    );

    assign fetch_ext = held_f.ext;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (pmem_rd_n && !fetch_ext));

    p_data_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        held_f.data |-> pmem_rd_n);

    p_int_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !fetch_ext |-> pmem_rd_n);

endmodule

// File: tb/pmem_strobe_ctrl_test.sv
module pmem_strobe_ctrl_test;

    localparam logic [11:0] PAT_ON  = 12'hC30;
    localparam logic [11:0] PAT_OFF = 12'hFFF;

    // {ea, addr[15:0], req, data, exp_ext, exp_act}
    localparam logic [20:0] VEC [0:7] = '{
        {1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 low internal
        {1'b1, 16'h3FFF, 1'b1, 1'b0, 1'b0, 1'b0},  // R2 top internal
        {1'b1, 16'h4000, 1'b1, 1'b0, 1'b1, 1'b1},  // R3 first external
        {1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 suppressed
        {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1},  // R4
        {1'b0, 16'h2000, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 R6
        {1'b0, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0},  // R10
        {1'b1, 16'h4000, 1'b0, 1'b0, 1'b0, 1'b0}   // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ea_pin = 1'b1;
    logic [2:0]  mc_state = 3'd5;
    logic        mc_phase = 1'b1;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = 16'h0;
    logic        xdata_cycle = 1'b0;
    logic        pmem_rd_n;
    logic        fetch_ext;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pmem_strobe_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .ea_pin      (ea_pin),
        .mc_state    (mc_state),
        .mc_phase    (mc_phase),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .xdata_cycle (xdata_cycle),
        .pmem_rd_n   (pmem_rd_n),
        .fetch_ext   (fetch_ext)
    );

    task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_reset(input logic ea);
        rst = 1'b1;
        ea_pin = ea;
        mc_state = 3'd2;
        mc_phase = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset strobe", {15'h0, pmem_rd_n}, 16'h1);
        check("R1 reset sel", {15'h0, fetch_ext}, 16'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", {14'h0, pmem_rd_n, fetch_ext}, 16'h2);
    endtask

    // One machine cycle; mid-cycle (from clock 2) the fetch inputs switch to m_*
    task automatic run_cycle(input logic req, input logic [15:0] addr, input logic data,
                             input logic m_req, input logic [15:0] m_addr, input logic m_data,
                             output logic [11:0] pat, output logic ext);
        ext = 1'b0;
        for (int k = 0; k < 12; k++) begin
            mc_state = 3'(k / 2);
            mc_phase = 1'(k % 2);
            if (k == 0) begin
                fetch_req = req; fetch_addr = addr; xdata_cycle = data;
            end else if (k == 2) begin
                fetch_req = m_req; fetch_addr = m_addr; xdata_cycle = m_data;
            end
            @(negedge clk);
            pat[k] = pmem_rd_n;
            if (k == 0) ext = fetch_ext;
        end
    endtask

    initial begin
        logic [11:0] pat;
        logic ext;
        for (int i = 0; i < 8; i++) begin
            logic [20:0] v;
            v = VEC[i];
            do_reset(v[20]);
            run_cycle(v[3], v[19:4], v[2], v[3], v[19:4], v[2], pat, ext);
            check("R2 R3 R4 R10 select", {15'h0, ext}, {15'h0, v[1]});
            check("R5 R6 R7 pattern", {4'h0, pat}, {4'h0, (v[0] ? PAT_ON : PAT_OFF)});
        end

        // R8: pin rises after reset with low latched value
        do_reset(1'b0);
        ea_pin = 1'b1;
        run_cycle(1'b1, 16'h0100, 1'b0, 1'b1, 16'h0100, 1'b0, pat, ext);
        check("R8 latched low sel", {15'h0, ext}, 16'h1);
        check("R8 latched low pattern", {4'h0, pat}, {4'h0, PAT_ON});
        // R8: pin falls after reset with high latched value
        do_reset(1'b1);
        ea_pin = 1'b0;
        run_cycle(1'b1, 16'h0100, 1'b0, 1'b1, 16'h0100, 1'b0, pat, ext);
        check("R8 latched high sel", {15'h0, ext}, 16'h0);
        check("R8 latched high pattern R7", {4'h0, pat}, {4'h0, PAT_OFF});

        // R9: external start, inputs turn internal/no-req/data mid-cycle
        run_cycle(1'b1, 16'h4000, 1'b0, 1'b0, 16'h0000, 1'b1, pat, ext);
        check("R9 ext kept", {15'h0, ext}, 16'h1);
        check("R9 pulses kept", {4'h0, pat}, {4'h0, PAT_ON});
        check("R9 sel held to end", {15'h0, fetch_ext}, 16'h1);
        // R9: internal start, address moves high mid-cycle
        run_cycle(1'b1, 16'h3FFF, 1'b0, 1'b1, 16'h8000, 1'b0, pat, ext);
        check("R9 int kept", {15'h0, ext}, 16'h0);
        check("R9 no pulses R7", {4'h0, pat}, {4'h0, PAT_OFF});

        // R6 back-to-back: external, collision, external again
        run_cycle(1'b1, 16'hC000, 1'b0, 1'b1, 16'hC000, 1'b0, pat, ext);
        check("R5 b2b first", {4'h0, pat}, {4'h0, PAT_ON});
        run_cycle(1'b1, 16'hC002, 1'b1, 1'b1, 16'hC002, 1'b1, pat, ext);
        check("R6 b2b collision pattern", {4'h0, pat}, {4'h0, PAT_OFF});
        check("R6 b2b collision sel", {15'h0, ext}, 16'h1);
        run_cycle(1'b1, 16'hC004, 1'b0, 1'b1, 16'hC004, 1'b0, pat, ext);
        check("R6 b2b recovers", {4'h0, pat}, {4'h0, PAT_ON});
        // R10 after an external cycle: no request clears select
        run_cycle(1'b0, 16'hC006, 1'b0, 1'b0, 16'hC006, 1'b0, pat, ext);
        check("R10 no req sel", {15'h0, ext}, 16'h0);
        check("R10 no req pattern", {4'h0, pat}, {4'h0, PAT_OFF});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule